// File: doc/BRIEF.md
# SDRAM Column Burst Data Path

This block runs the data phase of column bursts on the controller side of a single-data-rate SDRAM interface. A column command strobe brings a start column, a read/write flag and the active mode settings: burst length code, burst order and CAS latency. The block then produces one column address per clock for the burst. For writes it drives the write word and its byte mask onto the memory bus in step with each column. For reads it captures the returning 72-bit word (64 data bits plus an 8-bit check byte) at the cycle the programmed latency sets.

Any new column command ends the running burst and starts a new one on the next clock. A burst-stop strobe ends a burst of any length. The byte mask has no delay on the write side. On the read side it takes effect two cycles later, and the capture logic applies it by zeroing the masked lanes of the captured beat. Command legality and refresh are left to the surrounding controller.

Top module: `sdram_burst_path`

## Requirements
- R1: While `rst_n` is low, every output is zero.
- R2: A command sampled at edge k puts beat 0 (column = `cmd_col`, `col_write` = `cmd_write`) on the outputs after edge k, and beat i after edge k+i. The burst length code `mode_bl` selects 0→1, 1→2, 2→4, 3→8 or 7→full page beats. Codes 4, 5 and 6 behave as 1.
- R3: In sequential order (`mode_ilv`=0), the bits below the burst length count up from the start column and wrap inside the aligned block. The bits above it stay fixed.
- R4: In interleaved order (`mode_ilv`=1), beat i replaces the bits below the burst length with (start low bits XOR i).
- R5: A full-page burst counts up from the start column, wraps from 1023 to 0, ignores `mode_ilv`, never ends by itself and runs until it is stopped or interrupted.
- R6: `col_last` marks the final beat of every fixed-length burst that runs to its end. `rd_last` marks the captured read beat that belongs to that column beat. A full-page burst, or a burst that is cut short, gives no last marker.
- R7: A command sampled while a burst runs discards the rest of that burst. Its own beat 0 appears after the same edge.
- R8: `cmd_stop` sampled at edge s stops column beats from edge s on, and `dq_oe` drops with them. When `cmd_stop` and `cmd_valid` are both high, the stop wins.
- R9: For a write beat emitted at edge e, `dq_oe`=1 and `dq_out` = {`wr_check`,`wr_data`} as sampled at edge e. In every cycle, `mem_dqm` is the `dqm` value sampled at the previous edge. When no write beat is emitted, `dq_out` and `dq_oe` are zero.
- R10: A read beat emitted at edge e is captured from `dq_in` at edge e+CL+1, where CL = 2 + `mode_cl3` is latched with its command. `rd_valid` is high for exactly that one cycle. In all other cycles `rd_data` is zero.
- R11: `dqm` sampled at edge m zeroes data lane j (bits 8j+7..8j) of the read beat captured at edge m+2. The check byte (bits 71..64) is never masked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Column command strobe |
| cmd_write | input | 1 | 1 = write burst, 0 = read burst |
| cmd_stop | input | 1 | Burst-stop strobe |
| cmd_col | input | 10 | Start column |
| mode_bl | input | 3 | Burst length code |
| mode_ilv | input | 1 | 1 = interleaved order |
| mode_cl3 | input | 1 | 1 = CAS latency 3, 0 = CAS latency 2 |
| wr_data | input | 64 | Write data for the current beat |
| wr_check | input | 8 | Check byte for the current beat |
| dqm | input | 8 | Byte mask, one bit per data lane |
| dq_in | input | 72 | Data returned by the memory |
| col_valid | output | 1 | Column beat present |
| col_addr | output | 10 | Column of the current beat |
| col_write | output | 1 | Current beat is a write |
| col_last | output | 1 | Final beat of the burst |
| dq_out | output | 72 | Write word to the memory |
| dq_oe | output | 1 | Write data drive enable |
| mem_dqm | output | 8 | Byte mask to the memory |
| rd_valid | output | 1 | Captured read beat present |
| rd_data | output | 72 | Captured read beat |
| rd_last | output | 1 | Captured beat is the final one |

## Verification
All outputs are registered. A column beat, its write word and the forwarded mask show up one edge after the inputs that cause them. A read beat shows up CL+1 edges after its column beat, with lanes masked by `dqm` from two edges before capture. The bench drives inputs and compares each cycle at the falling edge, after exactly one rising edge. Its reference model steps once per edge, and keeps per-edge ring histories of mask and returned data plus a table of pending captures keyed by due edge. Every output is therefore compared in the one cycle it is due, and CL is changed only after the read pipeline has drained.

// File: rtl/sdbp_pkg.sv
package sdbp_pkg;

   localparam int unsigned CL_LO = 2;
   localparam int unsigned CL_HI = 3;
   localparam logic [2:0]  BL_PAGE_CODE = 3'd7;

   typedef struct packed {
      logic v;
      logic last;
      logic cl3;
   } rd_tag_t;

   function automatic int unsigned beats_of(input logic [2:0] code);
      case (code)
         3'd1:    return 2;
         3'd2:    return 4;
         3'd3:    return 8;
         default: return 1;
      endcase
   endfunction

endpackage

// File: rtl/sdbp_col_seq.sv
module sdbp_col_seq
   import sdbp_pkg::*;
#(
   parameter int unsigned COL_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_valid,
   input  logic             cmd_write,
   input  logic             cmd_stop,
   input  logic [COL_W-1:0] cmd_col,
   input  logic [2:0]       bl_code,
   input  logic             ilv,
   input  logic             cl3,
   output logic             issue_v,
   output logic             issue_wr,
   output logic             beat_v,
   output logic             beat_wr,
   output logic [COL_W-1:0] beat_col,
   output logic             beat_last,
   output logic             beat_cl3
);

   logic             act_q, wr_q, ilv_q, page_q, cl3_q;
   logic [COL_W-1:0] start_q, span_q, idx_q;
   logic             act_n, wr_n, ilv_n, page_n, cl3_n, last_n;
   logic [COL_W-1:0] start_n, span_n, idx_n, col_n;
   logic             cmd_page;
   logic [COL_W-1:0] cmd_span;

   assign cmd_page = (bl_code == BL_PAGE_CODE);
   assign cmd_span = cmd_page ? '1 : COL_W'(beats_of(bl_code) - 1);

   always_comb begin
      act_n   = act_q;
      wr_n    = wr_q;
      ilv_n   = ilv_q;
      page_n  = page_q;
      cl3_n   = cl3_q;
      start_n = start_q;
      span_n  = span_q;
      idx_n   = idx_q;
      col_n   = '0;
      last_n  = 1'b0;
      issue_v = 1'b0;
      issue_wr = 1'b0;
      if (cmd_stop) begin
         act_n = 1'b0;
      end else if (cmd_valid) begin
         issue_v  = 1'b1;
         issue_wr = cmd_write;
         wr_n     = cmd_write;
         ilv_n    = ilv & ~cmd_page;
         page_n   = cmd_page;
         cl3_n    = cl3;
         start_n  = cmd_col;
         span_n   = cmd_span;
         idx_n    = COL_W'(1);
         col_n    = cmd_col;
         last_n   = ~cmd_page && (cmd_span == '0);
         act_n    = ~last_n;
      end else if (act_q) begin
         issue_v  = 1'b1;
         issue_wr = wr_q;
         if (ilv_q)
            col_n = (start_q & ~span_q) | ((start_q ^ idx_q) & span_q);
         else
            col_n = (start_q & ~span_q) | ((start_q + idx_q) & span_q);
         last_n = ~page_q && (idx_q == span_q);
         idx_n  = idx_q + COL_W'(1);
         act_n  = ~last_n;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q     <= 1'b0;
         wr_q      <= 1'b0;
         ilv_q     <= 1'b0;
         page_q    <= 1'b0;
         cl3_q     <= 1'b0;
         start_q   <= '0;
         span_q    <= '0;
         idx_q     <= '0;
         beat_v    <= 1'b0;
         beat_wr   <= 1'b0;
         beat_col  <= '0;
         beat_last <= 1'b0;
         beat_cl3  <= 1'b0;
      end else begin
         act_q     <= act_n;
         wr_q      <= wr_n;
         ilv_q     <= ilv_n;
         page_q    <= page_n;
         cl3_q     <= cl3_n;
         start_q   <= start_n;
         span_q    <= span_n;
         idx_q     <= idx_n;
         beat_v    <= issue_v;
         beat_wr   <= issue_v & issue_wr;
         beat_col  <= col_n;
         beat_last <= last_n;
         beat_cl3  <= cl3_n;
      end
   end

   a_r8_stop_blocks_beat: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_stop |=> !beat_v);
   a_r6_last_needs_beat: assert property (@(posedge clk) disable iff (!rst_n)
      beat_last |-> beat_v);
   a_r2_burst_continues: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_v && !beat_last && !cmd_stop) |=> beat_v);

endmodule

// File: rtl/sdbp_wr_drive.sv
module sdbp_wr_drive #(
   parameter int unsigned DATA_W = 64,
   parameter int unsigned CHK_W  = 8,
   parameter int unsigned MASK_W = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_beat,
   input  logic [DATA_W-1:0]       wr_data,
   input  logic [CHK_W-1:0]        wr_check,
   input  logic [MASK_W-1:0]       dqm,
   output logic [DATA_W+CHK_W-1:0] dq_out,
   output logic                    dq_oe,
   output logic [MASK_W-1:0]       mem_dqm
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dq_out  <= '0;
         dq_oe   <= 1'b0;
         mem_dqm <= '0;
      end else begin
         dq_out  <= wr_beat ? {wr_check, wr_data} : '0;
         dq_oe   <= wr_beat;
         mem_dqm <= dqm;
      end
   end

endmodule

// File: rtl/sdbp_rd_align.sv
module sdbp_rd_align
   import sdbp_pkg::*;
#(
   parameter int unsigned DATA_W = 64,
   parameter int unsigned CHK_W  = 8,
   parameter int unsigned LANE_W = 8,
   parameter int unsigned CL_MAX = 3
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  rd_tag_t                 tag_in,
   input  logic [DATA_W+CHK_W-1:0] dq_in,
   input  logic [DATA_W/LANE_W-1:0] dqm,
   output logic                    rd_valid,
   output logic [DATA_W+CHK_W-1:0] rd_data,
   output logic                    rd_last
);

   localparam int unsigned NLANE = DATA_W / LANE_W;

   rd_tag_t          stage_q [CL_MAX];
   logic [CL_MAX-1:0] hit, hit_last;
   logic [NLANE-1:0] dqm_d1, dqm_d2;
   logic [DATA_W-1:0] masked;

   for (genvar j = 0; j < CL_MAX; j++) begin : g_stage
      if (j == 0) begin : g_head
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) stage_q[j] <= '0;
            else        stage_q[j] <= tag_in;
      end else begin : g_body
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) stage_q[j] <= '0;
            else        stage_q[j] <= stage_q[j-1];
      end
      assign hit[j]      = stage_q[j].v &&
                           (j == (stage_q[j].cl3 ? int'(CL_HI) - 1 : int'(CL_LO) - 1));
      assign hit_last[j] = hit[j] && stage_q[j].last;
   end

   for (genvar l = 0; l < NLANE; l++) begin : g_lane
      assign masked[l*LANE_W +: LANE_W] = dqm_d2[l] ? '0 : dq_in[l*LANE_W +: LANE_W];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dqm_d1   <= '0;
         dqm_d2   <= '0;
         rd_valid <= 1'b0;
         rd_data  <= '0;
         rd_last  <= 1'b0;
      end else begin
         dqm_d1   <= dqm;
         dqm_d2   <= dqm_d1;
         rd_valid <= |hit;
         rd_data  <= (|hit) ? {dq_in[DATA_W +: CHK_W], masked} : '0;
         rd_last  <= |hit_last;
      end
   end

   a_r10_capture_delay: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> ($past(tag_in.v, 3) || $past(tag_in.v, 4)));
   a_r6_rd_last_in_beat: assert property (@(posedge clk) disable iff (!rst_n)
      rd_last |-> rd_valid);

endmodule

// File: rtl/sdram_burst_path.sv
module sdram_burst_path
   import sdbp_pkg::*;
#(
   parameter int unsigned COL_W  = 10,
   parameter int unsigned DATA_W = 64,
   parameter int unsigned CHK_W  = 8,
   parameter int unsigned LANE_W = 8,
   parameter int unsigned CL_MAX = 3
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       cmd_valid,
   input  logic                       cmd_write,
   input  logic                       cmd_stop,
   input  logic [COL_W-1:0]           cmd_col,
   input  logic [2:0]                 mode_bl,
   input  logic                       mode_ilv,
   input  logic                       mode_cl3,
   input  logic [DATA_W-1:0]          wr_data,
   input  logic [CHK_W-1:0]           wr_check,
   input  logic [DATA_W/LANE_W-1:0]   dqm,
   input  logic [DATA_W+CHK_W-1:0]    dq_in,
   output logic                       col_valid,
   output logic [COL_W-1:0]           col_addr,
   output logic                       col_write,
   output logic                       col_last,
   output logic [DATA_W+CHK_W-1:0]    dq_out,
   output logic                       dq_oe,
   output logic [DATA_W/LANE_W-1:0]   mem_dqm,
   output logic                       rd_valid,
   output logic [DATA_W+CHK_W-1:0]    rd_data,
   output logic                       rd_last
);

   localparam int unsigned NLANE = DATA_W / LANE_W;

   initial begin
      a_p_lane_split: assert (DATA_W % LANE_W == 0);
      a_p_cl_depth:   assert (CL_MAX >= CL_HI);
      a_p_col_width:  assert (COL_W >= 3);
   end

   logic    issue_v, issue_wr, beat_cl3;
   rd_tag_t rd_tag;

   sdbp_col_seq #(.COL_W(COL_W)) i_seq (
      .clk(clk), .rst_n(rst_n),
      .cmd_valid(cmd_valid), .cmd_write(cmd_write), .cmd_stop(cmd_stop),
      .cmd_col(cmd_col), .bl_code(mode_bl), .ilv(mode_ilv), .cl3(mode_cl3),
      .issue_v(issue_v), .issue_wr(issue_wr),
      .beat_v(col_valid), .beat_wr(col_write), .beat_col(col_addr),
      .beat_last(col_last), .beat_cl3(beat_cl3)
   );

   sdbp_wr_drive #(.DATA_W(DATA_W), .CHK_W(CHK_W), .MASK_W(NLANE)) i_wr (
      .clk(clk), .rst_n(rst_n),
      .wr_beat(issue_v & issue_wr),
      .wr_data(wr_data), .wr_check(wr_check), .dqm(dqm),
      .dq_out(dq_out), .dq_oe(dq_oe), .mem_dqm(mem_dqm)
   );

   assign rd_tag.v    = col_valid & ~col_write;
   assign rd_tag.last = col_last;
   assign rd_tag.cl3  = beat_cl3;

   sdbp_rd_align #(.DATA_W(DATA_W), .CHK_W(CHK_W), .LANE_W(LANE_W), .CL_MAX(CL_MAX)) i_rd (
      .clk(clk), .rst_n(rst_n),
      .tag_in(rd_tag), .dq_in(dq_in), .dqm(dqm),
      .rd_valid(rd_valid), .rd_data(rd_data), .rd_last(rd_last)
   );

   a_r9_oe_on_write_beat: assert property (@(posedge clk) disable iff (!rst_n)
      dq_oe |-> (col_valid && col_write));

endmodule

// File: tb/test_sdram_burst_path.sv
module test_sdram_burst_path;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 0, cmd_write = 0, cmd_stop = 0;
   logic [9:0]  cmd_col = '0;
   logic [2:0]  mode_bl = '0;
   logic        mode_ilv = 0, mode_cl3 = 0;
   logic [63:0] wr_data = '0;
   logic [7:0]  wr_check = '0, dqm = '0;
   logic [71:0] dq_in = '0;
   logic        col_valid, col_write, col_last, dq_oe, rd_valid, rd_last;
   logic [9:0]  col_addr;
   logic [71:0] dq_out, rd_data;
   logic [7:0]  mem_dqm;

   int total = 0, bad = 0, edge_n = 0;
   bit finished = 0;

   // reference model state
   int m_act = 0, m_idx = 0, m_start = 0, m_len = 1, m_ilv = 0, m_cl = 2, m_wr = 0;
   int due_v[8], due_l[8];
   logic [7:0]  dqm_h[8];
   logic [71:0] e_dq, e_rd;
   logic [9:0]  e_col;
   logic [7:0]  e_mdqm;
   bit e_cv, e_cw, e_cl, e_oe, e_rv, e_rl;

   always #4 clk = ~clk;

   sdram_burst_path i_sdram_burst_path (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
      .cmd_stop(cmd_stop), .cmd_col(cmd_col), .mode_bl(mode_bl), .mode_ilv(mode_ilv),
      .mode_cl3(mode_cl3), .wr_data(wr_data), .wr_check(wr_check), .dqm(dqm),
      .dq_in(dq_in), .col_valid(col_valid), .col_addr(col_addr), .col_write(col_write),
      .col_last(col_last), .dq_out(dq_out), .dq_oe(dq_oe), .mem_dqm(mem_dqm),
      .rd_valid(rd_valid), .rd_data(rd_data), .rd_last(rd_last)
   );

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [71:0] act, input logic [71:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%h expected=%h (edge %0d)", tag, what, act, exp, edge_n);
      end
   endtask

   function automatic int len_of(input logic [2:0] c);
      case (c)
         3'd1: return 2;
         3'd2: return 4;
         3'd3: return 8;
         3'd7: return 0;
         default: return 1;
      endcase
   endfunction

   // one rising edge, then model + compare at the falling edge
   task automatic tick();
      string tc, trd;
      int ix, o, b, slot;
      bit was_act;
      @(posedge clk);
      @(negedge clk);
      edge_n++;
      slot = edge_n % 8;
      e_cv = 0; e_cw = 0; e_cl = 0; e_col = '0; e_oe = 0; e_dq = '0;
      e_rv = 0; e_rl = 0; e_rd = '0; e_mdqm = '0;
      tc = "R2";
      if (!rst_n) begin
         m_act = 0;
         for (int i = 0; i < 8; i++) begin due_v[i] = 0; due_l[i] = 0; dqm_h[i] = '0; end
         tc = "R1"; trd = "R1";
      end else begin
         was_act = (m_act != 0);
         ix = -1;
         if (cmd_stop) begin
            m_act = 0; tc = "R8";
         end else if (cmd_valid) begin
            m_start = cmd_col; m_len = len_of(mode_bl);
            m_ilv = (m_len != 0) && mode_ilv; m_cl = mode_cl3 ? 3 : 2; m_wr = cmd_write;
            ix = 0; m_idx = 1; m_act = (m_len != 1);
            if (was_act) tc = "R7";
         end else if (m_act != 0) begin
            ix = m_idx; m_idx = (m_idx + 1) % 1024;
            if (m_len != 0 && m_idx == m_len) m_act = 0;
         end
         if (ix >= 0) begin
            if (tc == "R2") tc = (m_len == 0) ? "R5" : m_ilv ? "R4" : (m_len > 1) ? "R3" : "R2";
            e_cv = 1; e_cw = m_wr;
            if (m_len == 0) e_col = 10'((m_start + ix) % 1024);
            else begin
               o = m_start % m_len; b = m_start - o;
               e_col = m_ilv ? 10'(b + (o ^ ix)) : 10'(b + (o + ix) % m_len);
            end
            e_cl = (m_len != 0) && (ix == m_len - 1);
            if (m_wr) begin e_oe = 1; e_dq = {wr_check, wr_data}; end
            else begin due_v[(edge_n + m_cl + 1) % 8] = 1; due_l[(edge_n + m_cl + 1) % 8] = e_cl; end
         end
         e_mdqm = dqm;
         trd = "R10";
         if (due_v[slot] != 0) begin
            e_rv = 1; e_rl = due_l[slot] != 0;
            e_rd = dq_in;
            for (int l = 0; l < 8; l++)
               if (dqm_h[(edge_n + 6) % 8][l]) begin e_rd[l*8 +: 8] = '0; trd = "R11"; end
            due_v[slot] = 0; due_l[slot] = 0;
         end
         dqm_h[slot] = dqm;
      end
      chk(col_valid === e_cv, tc, "col_valid", 72'(col_valid), 72'(e_cv));
      chk(col_addr === e_col, tc, "col_addr", 72'(col_addr), 72'(e_col));
      chk(col_write === e_cw, (tc == "R1") ? "R1" : "R2", "col_write", 72'(col_write), 72'(e_cw));
      chk(col_last === e_cl, (tc == "R1") ? "R1" : "R6", "col_last", 72'(col_last), 72'(e_cl));
      chk(dq_oe === e_oe, (tc == "R1" || tc == "R8") ? tc : "R9", "dq_oe", 72'(dq_oe), 72'(e_oe));
      chk(dq_out === e_dq, (tc == "R1") ? "R1" : "R9", "dq_out", dq_out, e_dq);
      chk(mem_dqm === e_mdqm, (tc == "R1") ? "R1" : "R9", "mem_dqm", 72'(mem_dqm), 72'(e_mdqm));
      chk(rd_valid === e_rv, trd, "rd_valid", 72'(rd_valid), 72'(e_rv));
      chk(rd_data === e_rd, trd, "rd_data", rd_data, e_rd);
      chk(rd_last === e_rl, (trd == "R1") ? "R1" : "R6", "rd_last", 72'(rd_last), 72'(e_rl));
      // next inputs
      cmd_valid = 0; cmd_stop = 0; cmd_write = 0;
      wr_data  = {$urandom, $urandom};
      wr_check = 8'($urandom);
      dqm      = ($urandom % 3 == 0) ? 8'($urandom) : 8'h00;
      dq_in    = {8'(edge_n ^ 8'h5A), 32'(edge_n * 32'h9E3779B1), $urandom};
   endtask

   task automatic cmd(input bit wr, input int col, input logic [2:0] bl,
                      input bit ilv, input bit cl3);
      cmd_valid = 1; cmd_write = wr; cmd_col = 10'(col);
      mode_bl = bl; mode_ilv = ilv; mode_cl3 = cl3;
      tick();
   endtask

   task automatic idle(input int n);
      repeat (n) tick();
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog: actual=hung expected=done");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      // R1: outputs held at zero during reset
      idle(3);
      rst_n = 1;
      idle(2);
      // R3 R6 R10: sequential BL4 read, CL2, start inside block
      cmd(0, 'h00D, 3'd2, 0, 0); idle(8);
      // R9 R3: sequential BL8 write wrapping in its block
      cmd(1, 'h1FB, 3'd3, 0, 0); idle(9);
      // R4: interleaved BL8 read and BL4 write
      cmd(0, 'h025, 3'd3, 1, 0); idle(4);
      cmd(1, 'h03E, 3'd2, 1, 0); idle(8);
      // R2: BL1, BL2 and reserved code 5 (one beat)
      cmd(0, 'h101, 3'd0, 0, 0); cmd(0, 'h203, 3'd1, 0, 0); idle(3);
      cmd(0, 'h300, 3'd5, 0, 0); idle(8);
      // R10 R7: CL3 back-to-back reads, second interrupts first
      cmd(0, 'h040, 3'd3, 0, 1); idle(2);
      cmd(0, 'h087, 3'd3, 1, 1); idle(12);
      // R5 R8: full page read across 1023, then stop
      cmd(0, 'h3FD, 3'd7, 1, 1); idle(6);
      cmd_stop = 1; tick(); idle(8);
      // R5 R7: full page write interrupted by a read
      cmd(1, 'h3FE, 3'd7, 1, 1); idle(4);
      cmd(0, 'h010, 3'd2, 0, 1); idle(10);
      // R8: stop during a write, stop and command together
      cmd(1, 'h120, 3'd3, 0, 0); idle(2);
      cmd_stop = 1; tick(); idle(2);
      cmd(1, 'h130, 3'd3, 0, 0); idle(1);
      cmd_valid = 1; cmd_stop = 1; cmd_col = 10'h155; tick(); idle(8);
      // R11 R9: reads with mask on every lane pattern, writes with masks
      for (int k = 0; k < 12; k++) begin
         cmd(k % 2, (k * 37) % 1024, 3'(k % 4), k[1], 0);
         idle(2);
      end
      idle(10);
      // R1: reset mid burst
      cmd(0, 'h222, 3'd7, 0, 0); idle(3);
      rst_n = 0; idle(2);
      rst_n = 1; idle(3);
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule